// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block is one bank of a vectored interrupt controller. It serves up to 32 request lines. Each line has its own configuration word, which sets three things: whether the line is delivered on the normal interrupt output or on the fast interrupt output, whether it is edge- or level-sensed, and a 5-bit priority. Requests are latched or followed according to their sense mode. Unmasked pending requests are arbitrated separately for the normal and the fast output. The winning source number is held on the output until software releases it through a control register.

The block has a small synchronous register port with one cycle of read latency. Banks can be chained: the normal output of a second-level bank drives one level-sensed input of a first-level bank. In a chained bank the fast routing is hard-wired off, set by the `FIRST_LEVEL` parameter. A global mask starts set after reset, and no interrupt is delivered until software clears it.

Top module: `ictl_bank`

## Requirements
- R1: After reset the mask register (offset 0x00) reads 0xFFFFFFFF, the global mask (offset 0x14, bit 0) reads 1, every configuration word reads 0, and `irq_o`/`fiq_o` are low.
- R2: Mask bit i set to 1 keeps source i out of arbitration, although its pending bit still latches. Mask bit i cleared to 0 lets source i take part.
- R3: Source i's configuration word sits at byte offset 0x40 + 4*i. In that word, bit 0 = 1 sends the source to the fast output (0 sends it to the normal output), bit 1 = 1 selects level sensing (0 selects edge), and bits 6:2 hold the priority. The 7 bits read back as written.
- R4: An edge-sensed source sets its pending bit on a rising input and keeps it after the input falls. The bit stays set until the source is acknowledged as the winner or cleared through the pending register.
- R5: The pending bit of a level-sensed source equals its current input.
- R6: Priority 0 is the most urgent. When priorities are equal, the lower source number wins.
- R7: Once a winner is captured, its number and the output stay unchanged until acknowledged, even if a more urgent request arrives.
- R8: A write to the control register (offset 0x10) with bit 0 set releases the normal arbitration, and with bit 1 set releases the fast arbitration. Each release is independent of the other. Releasing an edge-sensed winner clears its pending bit.
- R9: With `FIRST_LEVEL`=0, bit 0 of every configuration word is stored and read as 0, and `fiq_o` never asserts.
- R10: A write to the pending register (offset 0x04) clears every latched edge request whose written bit is 0.
- R11: While the global mask is 1, no winner is captured and both outputs stay low. Writing 0 to it enables delivery.
- R12: Read data appears in the cycle after the read strobe and is 0 otherwise. Reads of unmapped or misaligned offsets return 0, and writes to them change nothing. The winner registers at 0x08 (normal) and 0x0C (fast) hold the number in bits 4:0 and a valid flag in bit 8.
- R13: When a chained bank's `irq_o` drives a level-sensed input of a first-level bank, the first-level winner re-asserts after a first-level-only acknowledge. It drops only after both banks are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_id_o | output | ID_W | Captured normal winner number |
| fiq_id_o | output | ID_W | Captured fast winner number |

## Verification
The bench targets priority ties, where a design that scanned in the wrong direction would report the higher-numbered source. It also targets a more urgent request that arrives while a winner is held, where a non-freezing design would switch numbers mid-service. Further cases cover an acknowledge on one output that must leave the other output untouched, a masked edge request that must latch without firing, and a global mask that must hold captures off. The chained pair checks that the first-level winner returns until the second bank is released as well. Random priority sets on eight edge sources are drained one acknowledge at a time and compared against a bench ordering function.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  parameter int unsigned PRIO_W = 5;

  // bit 0: fast route, bit 1: level sense, bits 6:2: priority
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              lvl;
    logic              fiq;
  } src_cfg_t;

  parameter int unsigned CFG_W    = $bits(src_cfg_t);
  parameter int unsigned OFS_MASK = 'h00;
  parameter int unsigned OFS_PEND = 'h04;
  parameter int unsigned OFS_IWIN = 'h08;
  parameter int unsigned OFS_FWIN = 'h0C;
  parameter int unsigned OFS_CTRL = 'h10;
  parameter int unsigned OFS_GMSK = 'h14;
  parameter int unsigned OFS_CFG  = 'h40;
  parameter int unsigned VALID_BIT = 8;
endpackage

// File: rtl/ictl_pend.sv
module ictl_pend #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q, edge_q, rise;

  assign rise = src_i & ~src_q & ~lvl_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]  <= 1'b0;
        edge_q[i] <= 1'b0;
      end else begin
        src_q[i]  <= src_i[i];
        edge_q[i] <= rise[i] | (edge_q[i] & ~clr_i[i]); // new edge beats clear
      end
    end
    assign pend_o[i] = lvl_i[i] ? src_i[i] : edge_q[i];
  end

  AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edge_q & $past(rise)) == $past(rise))); // R4
endmodule

// File: rtl/ictl_arb.sv
module ictl_arb #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 5,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           valid_o,
  output logic [ID_W-1:0]                win_o
);
  logic [PRIO_W-1:0] best;

  // descending scan with <= leaves the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    win_o   = '0;
    best    = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!valid_o || prio_i[i] <= best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        win_o   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/ictl_bank.sv
module ictl_bank
  import ictl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter bit          FIRST_LEVEL = 1'b1,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  localparam int unsigned ID_W       = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic [ID_W-1:0]    fiq_id_o
);
  localparam int unsigned CFG_END = OFS_CFG + 4 * NUM_SRC;
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  logic [NUM_SRC-1:0] mask_q, pend, elig, lvl_vec, fiq_vec, clr;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
  src_cfg_t [NUM_SRC-1:0] cfg_q;
  logic gmask_q, irq_valid_q, fiq_valid_q;
  logic [ID_W-1:0] irq_id_q, fiq_id_q, iarb_w, farb_w, cfg_idx;
  logic iarb_v, farb_v;
  logic [ADDR_W-1:0] cfg_off;
  logic wr_mask, wr_pend, wr_ctrl, wr_gmsk, cfg_hit, ack_irq, ack_fiq;
  logic [DATA_W-1:0] rd_val, rdata_q;

  // register decode
  assign wr_mask = reg_we_i && int'(reg_addr_i) == OFS_MASK;
  assign wr_pend = reg_we_i && int'(reg_addr_i) == OFS_PEND;
  assign wr_ctrl = reg_we_i && int'(reg_addr_i) == OFS_CTRL;
  assign wr_gmsk = reg_we_i && int'(reg_addr_i) == OFS_GMSK;
  assign cfg_hit = int'(reg_addr_i) >= OFS_CFG && int'(reg_addr_i) < CFG_END &&
                   reg_addr_i[1:0] == 2'b00;
  assign cfg_off = reg_addr_i - ADDR_W'(OFS_CFG);
  assign cfg_idx = cfg_off[ID_W+1:2];
  assign ack_irq = wr_ctrl && reg_wdata_i[0];
  assign ack_fiq = wr_ctrl && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      gmask_q <= 1'b1;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      if (wr_gmsk) gmask_q <= reg_wdata_i[0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
      end else if (reg_we_i && cfg_hit && cfg_idx == ID_W'(i)) begin
        cfg_q[i]     <= src_cfg_t'(reg_wdata_i[CFG_W-1:0]);
        cfg_q[i].fiq <= reg_wdata_i[0] & FIRST_LEVEL;
      end
    end
    assign lvl_vec[i]  = cfg_q[i].lvl;
    assign fiq_vec[i]  = cfg_q[i].fiq;
    assign prio_vec[i] = cfg_q[i].prio;
  end

  // request capture
  assign clr = (ack_irq && irq_valid_q ? ONE << irq_id_q : '0) |
               (ack_fiq && fiq_valid_q ? ONE << fiq_id_q : '0) |
               (wr_pend ? ~reg_wdata_i[NUM_SRC-1:0] : '0);

  ictl_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .lvl_i  (lvl_vec),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign elig = pend & ~mask_q;

  ictl_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb_irq (
    .cand_i  (elig & ~fiq_vec),
    .prio_i  (prio_vec),
    .valid_o (iarb_v),
    .win_o   (iarb_w)
  );

  ictl_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb_fiq (
    .cand_i  (elig & fiq_vec),
    .prio_i  (prio_vec),
    .valid_o (farb_v),
    .win_o   (farb_w)
  );

  // winner hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_q <= 1'b0;
      irq_id_q    <= '0;
      fiq_valid_q <= 1'b0;
      fiq_id_q    <= '0;
    end else begin
      if (ack_irq) begin
        irq_valid_q <= 1'b0;
        irq_id_q    <= '0;
      end else if (!irq_valid_q && iarb_v && !gmask_q) begin
        irq_valid_q <= 1'b1;
        irq_id_q    <= iarb_w;
      end
      if (ack_fiq) begin
        fiq_valid_q <= 1'b0;
        fiq_id_q    <= '0;
      end else if (!fiq_valid_q && farb_v && !gmask_q) begin
        fiq_valid_q <= 1'b1;
        fiq_id_q    <= farb_w;
      end
    end
  end

  assign irq_o    = irq_valid_q & ~gmask_q;
  assign fiq_o    = fiq_valid_q & ~gmask_q;
  assign irq_id_o = irq_id_q;
  assign fiq_id_o = fiq_id_q;

  // read port
  always_comb begin
    rd_val = '0;
    case (int'(reg_addr_i))
      OFS_MASK: rd_val = DATA_W'(mask_q);
      OFS_PEND: rd_val = DATA_W'(pend);
      OFS_IWIN: rd_val = DATA_W'({irq_valid_q, {(VALID_BIT - ID_W){1'b0}}, irq_id_q});
      OFS_FWIN: rd_val = DATA_W'({fiq_valid_q, {(VALID_BIT - ID_W){1'b0}}, fiq_id_q});
      OFS_GMSK: rd_val = DATA_W'(gmask_q);
      default:  if (cfg_hit) rd_val = DATA_W'(cfg_q[cfg_idx]);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= reg_re_i ? rd_val : '0;
  end
  assign reg_rdata_o = rdata_q;

  AST_WIN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_q && !ack_irq |=> irq_valid_q && $stable(irq_id_q)); // R7
  AST_NO_FIQ_CHAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FIRST_LEVEL |-> !fiq_o); // R9
  AST_CAPTURE_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_q) |-> (($past(mask_q) >> irq_id_q) & ONE) == '0); // R2
  AST_GMASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_q) || $rose(fiq_valid_q) |-> !$past(gmask_q)); // R11
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> reg_rdata_o == '0); // R12
endmodule

// File: tb/ictl_bank_tb.sv
module ictl_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] src_b = '0, csrc = '0;
  logic        we [2], re [2];
  logic [7:0]  addr [2];
  logic [31:0] wdata [2], rdata [2];
  logic        irq [2], fiq [2];
  logic [4:0]  iid [2], fid [2];
  logic [4:0]  pr [32];
  int checks = 0, errors = 0;
  bit  done = 0;

  initial begin
    for (int b = 0; b < 2; b++) begin
      we[b] = 0; re[b] = 0; addr[b] = '0; wdata[b] = '0;
    end
  end

  ictl_bank #(.FIRST_LEVEL(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i({src_b[31:1], irq[1]}),
    .reg_we_i(we[0]), .reg_re_i(re[0]), .reg_addr_i(addr[0]),
    .reg_wdata_i(wdata[0]), .reg_rdata_o(rdata[0]),
    .irq_o(irq[0]), .fiq_o(fiq[0]), .irq_id_o(iid[0]), .fiq_id_o(fid[0]));

  ictl_bank #(.FIRST_LEVEL(1'b0)) u_casc (
    .clk_i(clk), .rst_ni(rst_n), .src_i(csrc),
    .reg_we_i(we[1]), .reg_re_i(re[1]), .reg_addr_i(addr[1]),
    .reg_wdata_i(wdata[1]), .reg_rdata_o(rdata[1]),
    .irq_o(irq[1]), .fiq_o(fiq[1]), .irq_id_o(iid[1]), .fiq_id_o(fid[1]));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int b, int a, logic [31:0] d);
    @(negedge clk); we[b] = 1; addr[b] = 8'(a); wdata[b] = d;
    @(negedge clk); we[b] = 0;
  endtask

  task automatic rd(int b, int a, output logic [31:0] d);
    @(negedge clk); re[b] = 1; addr[b] = 8'(a);
    @(negedge clk); re[b] = 0; d = rdata[b];
  endtask

  task automatic pulse(logic [31:0] bits);
    @(negedge clk); src_b = src_b | bits;
    @(negedge clk); src_b = src_b & ~bits;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int pick(logic [31:0] p);
    int w = -1;
    int best = 99;
    for (int i = 0; i < 32; i++)
      if (p[i] && int'(pr[i]) < best) begin best = int'(pr[i]); w = i; end
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, model;
    logic [31:0] used;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", 32'(irq[0]), 0);
    chk("R1 fiq", 32'(fiq[0]), 0);
    rd(0, 'h00, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(0, 'h14, d); chk("R1 gmask", d, 1);
    rd(0, 'h54, d); chk("R1 cfg", d, 0);
    // R12 unmapped and misaligned
    rd(0, 'h30, d); chk("R12 unmapped read", d, 0);
    wr(0, 'h30, 32'h0000_FFFF);
    rd(0, 'h00, d); chk("R12 unmapped write", d, 32'hFFFF_FFFF);
    wr(0, 'h42, 32'h7F);
    rd(0, 'h40, d); chk("R12 misaligned write", d, 0);
    // R3 layout
    wr(0, 'h54, 32'h7F);
    rd(0, 'h54, d); chk("R3 readback", d, 32'h7F);
    wr(0, 'h54, 0);
    // R9 chained bank drops fast route
    wr(1, 'h4C, 32'h7F);
    rd(1, 'h4C, d); chk("R9 fiq bit forced", d, 32'h7E);
    wr(1, 'h4C, 0);
    // first-level setup
    wr(0, 'h40, 32'h02);           // src0 level prio0 (chain input)
    wr(0, 'h44, 32'h00);           // src1 prio0
    wr(0, 'h48, 32'h04);           // src2 prio1
    wr(0, 'h50, 32'h0C);           // src4 prio3
    wr(0, 'h5C, 32'h0C);           // src7 prio3
    wr(0, 'h64, 32'h7E);           // src9 level prio31
    wr(0, 'h6C, 32'h01);           // src11 fast
    used = 32'h000F_FA97;
    wr(0, 'h00, ~used);
    // R11 global mask
    pulse(32'h4); settle();
    chk("R11 blocked", 32'(irq[0]), 0);
    wr(0, 'h14, 0); settle();
    chk("R11 enabled irq", 32'(irq[0]), 1);
    chk("R11 enabled id", 32'(iid[0]), 2);
    // R7 freeze
    pulse(32'h2); settle();
    chk("R7 held id", 32'(iid[0]), 2);
    rd(0, 'h08, d); chk("R12 winner reg", d, 32'h102);
    // R8 release
    wr(0, 'h10, 1); settle();
    chk("R6 more urgent next", 32'(iid[0]), 1);
    rd(0, 'h04, d); chk("R8 pending cleared", d & 32'h6, 32'h2);
    wr(0, 'h10, 1); settle();
    chk("R8 idle", 32'(irq[0]), 0);
    // R6 tie
    pulse(32'h90); settle();
    chk("R6 tie low number", 32'(iid[0]), 4);
    wr(0, 'h10, 1); settle();
    chk("R6 tie second", 32'(iid[0]), 7);
    wr(0, 'h10, 1); settle();
    chk("R6 drained", 32'(irq[0]), 0);
    // R5 level follows
    @(negedge clk); src_b[9] = 1;
    rd(0, 'h04, d); chk("R5 level high", 32'(d[9]), 1);
    @(negedge clk); src_b[9] = 0;
    rd(0, 'h04, d); chk("R5 level low", 32'(d[9]), 0);
    wr(0, 'h10, 1); settle();
    chk("R5 released", 32'(irq[0]), 0);
    // R2 / R4 / R10 on masked source 20
    pulse(32'h0010_0000); settle();
    chk("R2 masked no irq", 32'(irq[0]), 0);
    rd(0, 'h04, d); chk("R4 edge held", 32'(d[20]), 1);
    wr(0, 'h04, 0);
    rd(0, 'h04, d); chk("R10 pending clear", d, 0);
    // fast path and independent release
    pulse(32'h800); settle();
    chk("R3 fast route", 32'(fiq[0]), 1);
    chk("R3 fast id", 32'(fid[0]), 11);
    chk("R3 not on irq", 32'(irq[0]), 0);
    wr(0, 'h10, 1); settle();
    chk("R8 fiq unaffected", 32'(fiq[0]), 1);
    wr(0, 'h10, 2); settle();
    chk("R8 fiq released", 32'(fiq[0]), 0);
    // R13 chain
    wr(1, 'h14, 0);
    wr(1, 'h00, ~32'h20);
    @(negedge clk); csrc[5] = 1;
    @(negedge clk); csrc[5] = 0;
    settle();
    chk("R13 chained irq", 32'(irq[1]), 1);
    chk("R13 first-level id", 32'(iid[0]), 0);
    wr(0, 'h10, 1); settle();
    chk("R13 re-asserts", 32'(irq[0]), 1);
    chk("R13 re-asserts id", 32'(iid[0]), 0);
    wr(1, 'h10, 1); wr(0, 'h10, 1); settle();
    chk("R13 both released", 32'(irq[0]), 0);
    chk("R13 chained low", 32'(irq[1]), 0);
    chk("R9 chained fiq", 32'(fiq[1]), 0);
    // random priority sets, R6
    for (int it = 0; it < 20; it++) begin
      for (int k = 12; k < 20; k++) begin
        pr[k] = 5'($urandom % 32);
        wr(0, 'h40 + 4 * k, {25'd0, pr[k], 2'b00});
      end
      model = {12'd0, 8'($urandom), 12'd0};
      if (model == 0) model = 32'h1000;
      pulse(model);
      while (model != 0) begin
        settle();
        chk("R6 random irq", 32'(irq[0]), 1);
        chk("R6 random id", 32'(iid[0]), 32'(pick(model)));
        model[pick(model)] = 1'b0;
        wr(0, 'h10, 1);
      end
      settle();
      chk("R6 random drained", 32'(irq[0]), 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule